// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Distributed Refresh

This block sits between a simple single-bit host port and a 16K x 1 dynamic RAM whose 14 address bits share one 7-bit pin bus. For each accepted host request it runs one complete strobe cycle. The row half of the address goes out first and is latched by the row strobe. The bus is then switched to the column half, and the column strobe is lowered. A read captures the returned data bit before the column strobe rises. Both strobes then stay high for a precharge gap, and the cycle is stretched until it meets a programmable minimum length. Every delay is a count in clocks, set by a parameter.

An internal interval timer raises a refresh request at a fixed cadence. Each request causes one row-only refresh cycle. In that cycle the row strobe pulses low on the address of a wrapping 7-bit counter, and the column strobe stays high. At the default 250 MHz clock the cadence is 3900 clocks, so all 128 rows are refreshed in about 2 ms. A pending refresh always wins over the host when the sequencer is idle. The host sees this as a low `host_ready`. A sticky flag records that a request was still waiting when the next one arrived.

Top module: `mxd_dram_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are 1, `host_ready` is 1, `host_rvalid` is 0 and `ref_overdue` is 0.
- R2: In a host cycle the bus carries `host_addr[13:7]` when `dram_ras_n` falls and `host_addr[6:0]` when `dram_cas_n` falls. `dram_cas_n` is low only while `dram_ras_n` is low.
- R3: For a write (`host_we`=1), `dram_we_n` is already low in the cycle before `dram_cas_n` falls and holds steady while `dram_cas_n` is low. The addressed cell then holds `host_wdata`.
- R4: For a read, the data bit is taken in the last cycle of the column strobe. `host_rdata` is presented with a single-cycle `host_rvalid` pulse, in the first cycle after `dram_cas_n` rises. There is exactly one pulse per read and none for a write.
- R5: A refresh cycle pulses `dram_ras_n` low while `dram_cas_n` and `dram_we_n` stay high. The refreshed row starts at 0 after reset and advances by 1 modulo 128 with each refresh.
- R6: A refresh request is raised every REF_INTERVAL clocks, the first one REF_INTERVAL clocks after reset. Its row strobe falls within T_RC+4 clocks of the request.
- R7: When a refresh is pending and the sequencer is idle, the refresh starts before any host cycle. `host_ready` is 0 whenever a refresh is pending or a cycle is running. A request made during a refresh is held and is serviced after the refresh.
- R8: Successive falling edges of `dram_ras_n` are more than T_RC clocks apart.
- R9: `ref_overdue` goes to 1 and stays there if the interval timer expires again while an earlier refresh request is still waiting. If the interval is longer than the worst-case wait, it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Host request; accepted on a clock edge where `host_ready` is 1 |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 14 | Cell address, row in [13:7], column in [6:0] |
| host_wdata | input | 1 | Write data bit |
| host_ready | output | 1 | Controller idle with no refresh pending |
| host_rvalid | output | 1 | One-cycle pulse marking `host_rdata` valid |
| host_rdata | output | 1 | Captured read data bit |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | 7 | Multiplexed row/column address |
| dram_din | output | 1 | Data bit to the memory |
| dram_dout | input | 1 | Data bit from the memory |
| ref_overdue | output | 1 | Sticky flag: a refresh request waited across a whole interval |

## Verification
The hardest condition to reach is a refresh request that arrives while a host cycle is running, so that the refresh has to wait at the idle boundary. A second case is a host request that is asserted in the middle of a refresh. A long address sweep runs with a short refresh interval, so the timer expires at many different phases of the host cycles. A directed step waits for a row strobe that no column strobe follows and issues a write right then. The overdue flag is driven by a second instance whose interval is shorter than one refresh cycle.

// File: rtl/mxd_pkg.sv
package mxd_pkg;

    localparam int ROW_BITS  = 7;
    localparam int COL_BITS  = 7;
    localparam int ADDR_BITS = ROW_BITS + COL_BITS;
    localparam int NUM_ROWS  = 1 << ROW_BITS;

    typedef logic [ROW_BITS-1:0]  row_t;
    typedef logic [COL_BITS-1:0]  col_t;
    typedef logic [ADDR_BITS-1:0] addr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_RAS,
        ST_COL,
        ST_CAS,
        ST_REF_ROW,
        ST_REF_RAS,
        ST_PRE
    } seq_state_e;

    // latched access: what the sequencer works on for one cycle
    typedef struct packed {
        logic we;
        logic wd;
        row_t row;
        col_t col;
    } acc_t;

    // strobe levels decoded from the state
    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic col_sel;
    } strobe_t;

    function automatic row_t row_of(addr_t a);
        return a[ADDR_BITS-1 -: ROW_BITS];
    endfunction

    function automatic col_t col_of(addr_t a);
        return a[COL_BITS-1:0];
    endfunction

    function automatic strobe_t strobes_for(seq_state_e s, logic we);
        strobe_t r;
        r.ras_n   = !(s == ST_RAS || s == ST_COL || s == ST_CAS || s == ST_REF_RAS);
        r.cas_n   = !(s == ST_CAS);
        r.we_n    = !((s == ST_COL || s == ST_CAS) && we);
        r.col_sel = (s == ST_COL || s == ST_CAS);
        return r;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mxd_refresh_sched.sv
module mxd_refresh_sched
    import mxd_pkg::*;
#(
    parameter int REF_INTERVAL = 3900
) (
    input  logic clk,
    input  logic rst,
    input  logic grant,
    output logic pend,
    output row_t row,
    output logic overdue
);
    localparam int CNT_W = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(REF_INTERVAL - 1);

    logic [CNT_W-1:0] cnt;
    logic             expire;

    assign expire = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= CNT_TOP;
            pend    <= 1'b0;
            overdue <= 1'b0;
            row     <= '0;
        end else begin
            cnt <= expire ? CNT_TOP : cnt - 1'b1;
            if (expire) begin
                if (pend && !grant)
                    overdue <= 1'b1;
                pend <= 1'b1;
            end else if (grant) begin
                pend <= 1'b0;
            end
            if (grant)
                row <= row + 1'b1;
        end
    end

endmodule

// File: rtl/mxd_addr_mux.sv
module mxd_addr_mux
    import mxd_pkg::*;
(
    input  logic col_sel,
    input  row_t row,
    input  col_t col,
    output logic [ROW_BITS-1:0] addr
);
    localparam int BUS_W = max2(ROW_BITS, COL_BITS);

    logic [BUS_W-1:0] row_w;
    logic [BUS_W-1:0] col_w;

    assign row_w = BUS_W'(row);
    assign col_w = BUS_W'(col);

    for (genvar b = 0; b < ROW_BITS; b++) begin : g_bit
        assign addr[b] = col_sel ? col_w[b] : row_w[b];
    end

endmodule

// File: rtl/mxd_seq.sv
module mxd_seq
    import mxd_pkg::*;
#(
    parameter int T_RCD     = 5,
    parameter int T_CAS     = 32,
    parameter int T_RP      = 25,
    parameter int T_RC      = 80,
    parameter int T_REF_RAS = 38
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_req,
    input  logic       host_we,
    input  addr_t      host_addr,
    input  logic       host_wdata,
    input  logic       ref_pend,
    input  row_t       ref_row,
    input  logic       dram_dout,
    output logic       host_ready,
    output logic       ref_grant,
    output logic       host_rvalid,
    output logic       host_rdata,
    output strobe_t    strb,
    output acc_t       acc,
    output seq_state_e st
);
    localparam int TMAX  = max2(max2(T_RCD, T_CAS), max2(T_RP, max2(T_RC, T_REF_RAS)));
    localparam int TMR_W = $clog2(TMAX + 1);
    localparam logic [TMR_W-1:0] LD_RCD = TMR_W'(T_RCD - 1);
    localparam logic [TMR_W-1:0] LD_CAS = TMR_W'(T_CAS - 1);
    localparam logic [TMR_W-1:0] LD_RP  = TMR_W'(T_RP - 1);
    localparam logic [TMR_W-1:0] LD_REF = TMR_W'(T_REF_RAS - 1);
    localparam logic [TMR_W-1:0] CYC_LIM = TMR_W'(T_RC - 1);

    logic [TMR_W-1:0] tmr;
    logic [TMR_W-1:0] cyc;
    logic             tmr_done;

    assign tmr_done   = (tmr == '0);
    assign host_ready = (st == ST_IDLE) && !ref_pend;
    assign ref_grant  = (st == ST_IDLE) && ref_pend;
    assign strb       = strobes_for(st, acc.we);

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            tmr         <= '0;
            cyc         <= '0;
            acc         <= '0;
            host_rvalid <= 1'b0;
            host_rdata  <= 1'b0;
        end else begin
            host_rvalid <= 1'b0;
            if (st != ST_IDLE && cyc != CYC_LIM)
                cyc <= cyc + 1'b1;
            unique case (st)
                ST_IDLE: begin
                    cyc <= '0;
                    if (ref_pend) begin
                        acc.we  <= 1'b0;
                        acc.wd  <= 1'b0;
                        acc.row <= ref_row;
                        acc.col <= '0;
                        st      <= ST_REF_ROW;
                    end else if (host_req) begin
                        acc.we  <= host_we;
                        acc.wd  <= host_wdata;
                        acc.row <= row_of(host_addr);
                        acc.col <= col_of(host_addr);
                        st      <= ST_ROW;
                    end
                end
                ST_ROW: begin
                    tmr <= LD_RCD;
                    st  <= ST_RAS;
                end
                ST_RAS: begin
                    if (tmr_done) st <= ST_COL;
                    else          tmr <= tmr - 1'b1;
                end
                ST_COL: begin
                    tmr <= LD_CAS;
                    st  <= ST_CAS;
                end
                ST_CAS: begin
                    if (tmr_done) begin
                        if (!acc.we) begin
                            host_rdata  <= dram_dout;
                            host_rvalid <= 1'b1;
                        end
                        tmr <= LD_RP;
                        st  <= ST_PRE;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_REF_ROW: begin
                    tmr <= LD_REF;
                    st  <= ST_REF_RAS;
                end
                ST_REF_RAS: begin
                    if (tmr_done) begin
                        tmr <= LD_RP;
                        st  <= ST_PRE;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_PRE: begin
                    if (!tmr_done)
                        tmr <= tmr - 1'b1;
                    else if (cyc == CYC_LIM)
                        st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mxd_dram_ctrl.sv
module mxd_dram_ctrl
    import mxd_pkg::*;
#(
    parameter int REF_INTERVAL = 3900,
    parameter int T_RCD        = 5,
    parameter int T_CAS        = 32,
    parameter int T_RP         = 25,
    parameter int T_RC         = 80,
    parameter int T_REF_RAS    = 38
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_req,
    input  logic        host_we,
    input  logic [13:0] host_addr,
    input  logic        host_wdata,
    output logic        host_ready,
    output logic        host_rvalid,
    output logic        host_rdata,
    output logic        dram_ras_n,
    output logic        dram_cas_n,
    output logic        dram_we_n,
    output logic [6:0]  dram_addr,
    output logic        dram_din,
    input  logic        dram_dout,
    output logic        ref_overdue
);
    logic       ref_pend;
    logic       ref_grant;
    row_t       ref_row;
    strobe_t    strb;
    acc_t       acc;
    seq_state_e seq_st;

    mxd_refresh_sched #(
        .REF_INTERVAL(REF_INTERVAL)
    ) u_sched (
        .clk    (clk),
        .rst    (rst),
        .grant  (ref_grant),
        .pend   (ref_pend),
        .row    (ref_row),
        .overdue(ref_overdue)
    );

    mxd_seq #(
        .T_RCD    (T_RCD),
        .T_CAS    (T_CAS),
        .T_RP     (T_RP),
        .T_RC     (T_RC),
        .T_REF_RAS(T_REF_RAS)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .ref_pend   (ref_pend),
        .ref_row    (ref_row),
        .dram_dout  (dram_dout),
        .host_ready (host_ready),
        .ref_grant  (ref_grant),
        .host_rvalid(host_rvalid),
        .host_rdata (host_rdata),
        .strb       (strb),
        .acc        (acc),
        .st         (seq_st)
    );

    mxd_addr_mux u_mux (
        .col_sel(strb.col_sel),
        .row    (acc.row),
        .col    (acc.col),
        .addr   (dram_addr)
    );

    assign dram_ras_n = strb.ras_n;
    assign dram_cas_n = strb.cas_n;
    assign dram_we_n  = strb.we_n;
    assign dram_din   = acc.wd;

endmodule

// File: rtl/mxd_ctrl_chk.sv
module mxd_ctrl_chk
    import mxd_pkg::*;
#(
    parameter int T_RC = 80
) (
    input logic       clk,
    input logic       rst,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic       host_ready,
    input logic       host_rvalid,
    input logic       ref_pend,
    input logic       ref_grant,
    input row_t       ref_row,
    input seq_state_e st
);
    logic [15:0] gap;
    logic        ras_q;
    logic        seen;
    logic        ras_fall;

    assign ras_fall = ras_q && !ras_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap   <= '0;
            ras_q <= 1'b1;
            seen  <= 1'b0;
        end else begin
            ras_q <= ras_n;
            if (ras_fall) begin
                gap  <= 16'd1;
                seen <= 1'b1;
            end else if (gap != 16'hFFFF) begin
                gap <= gap + 1'b1;
            end
        end
    end

    // R2
    cas_in_ras_chk: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> !ras_n);

    // R3
    we_before_cas_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n) |-> $stable(we_n));

    // R3
    we_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cas_n && !$fell(cas_n)) |-> $stable(we_n));

    // R4
    rvalid_single_chk: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |=> !host_rvalid);

    // R5
    ref_only_ras_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_REF_RAS) |-> (cas_n && we_n && !ras_n));

    // R5
    ref_row_step_chk: assert property (@(posedge clk) disable iff (rst)
        ref_grant |=> (ref_row == 7'($past(ref_row) + 1'b1)));

    // R7
    ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
        host_ready |-> !ref_pend);

    // R7
    ref_first_chk: assert property (@(posedge clk) disable iff (rst)
        ref_grant |=> (st == ST_REF_ROW));

    // R8
    ras_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (ras_fall && seen) |-> (gap >= 16'(T_RC)));

endmodule

bind mxd_dram_ctrl mxd_ctrl_chk #(.T_RC(T_RC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ras_n      (dram_ras_n),
    .cas_n      (dram_cas_n),
    .we_n       (dram_we_n),
    .host_ready (host_ready),
    .host_rvalid(host_rvalid),
    .ref_pend   (ref_pend),
    .ref_grant  (ref_grant),
    .ref_row    (ref_row),
    .st         (seq_st)
);

// File: tb/sim_mxd_dram_ctrl.sv
`timescale 1ns/1ps
module sim_mxd_dram_ctrl;

    localparam int REF  = 150;
    localparam int RCD  = 2;
    localparam int CASN = 3;
    localparam int RP   = 2;
    localparam int RC   = 12;
    localparam int RREF = 4;
    localparam int NACC = 512;
    localparam int WDOG = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [13:0] host_addr = '0;
    logic        host_wdata = 1'b0;
    logic        host_ready, host_rvalid, host_rdata;
    logic        ras_n, cas_n, we_n, din, dout;
    logic [6:0]  dbus;
    logic        overdue;

    logic        u1_ready, u1_rvalid, u1_rdata, u1_ras, u1_cas, u1_we, u1_din, u1_od;
    logic [6:0]  u1_addr;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit started = 0;

    always #2 clk = ~clk;

    mxd_dram_ctrl #(
        .REF_INTERVAL(REF), .T_RCD(RCD), .T_CAS(CASN), .T_RP(RP), .T_RC(RC), .T_REF_RAS(RREF)
    ) u0 (
        .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ready(host_ready), .host_rvalid(host_rvalid),
        .host_rdata(host_rdata), .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
        .dram_addr(dbus), .dram_din(din), .dram_dout(dout), .ref_overdue(overdue)
    );

    mxd_dram_ctrl #(
        .REF_INTERVAL(4), .T_RCD(RCD), .T_CAS(CASN), .T_RP(RP), .T_RC(RC), .T_REF_RAS(RREF)
    ) u1 (
        .clk(clk), .rst(rst), .host_req(1'b0), .host_we(1'b0), .host_addr(14'd0),
        .host_wdata(1'b0), .host_ready(u1_ready), .host_rvalid(u1_rvalid),
        .host_rdata(u1_rdata), .dram_ras_n(u1_ras), .dram_cas_n(u1_cas), .dram_we_n(u1_we),
        .dram_addr(u1_addr), .dram_din(u1_din), .dram_dout(1'b0), .ref_overdue(u1_od)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // memory model
    logic [16383:0] mem = '0;
    logic [6:0] row_l = '0, col_l = '0;
    logic ras_p = 1'b1, cas_p = 1'b1, cas_seen = 1'b0;
    int   fall_t = 0, last_ref_t = -1, n_ref = 0, exp_ref_row = 0;
    int   n_rvalid = 0, r7_viol = 0, last_fall = -1, r8_viol = 0;

    assign dout = mem[{row_l, col_l}];

    always @(posedge clk) if (started) cyc++;

    always @(negedge clk) begin
        if (!rst) begin
            if (ras_p && !ras_n) begin
                row_l = dbus;
                cas_seen = 1'b0;
                if (last_fall >= 0 && cyc - last_fall <= RC) r8_viol++;
                last_fall = cyc;
                fall_t = cyc;
            end
            if (cas_p && !cas_n) begin
                col_l = dbus;
                cas_seen = 1'b1;
                if (!we_n) mem[{row_l, dbus}] = din;
            end
            if (!ras_p && ras_n && !cas_seen) begin
                // R5 refresh row sequence
                chk(row_l == 7'(exp_ref_row), "R5 refresh row", row_l, exp_ref_row);
                exp_ref_row = (exp_ref_row + 1) % 128;
                // R6 cadence
                if (last_ref_t < 0)
                    chk(fall_t >= REF - 1 && fall_t <= REF + RC + 6, "R6 first refresh", fall_t, REF);
                else
                    chk((fall_t - last_ref_t) >= REF - RC - 4 && (fall_t - last_ref_t) <= REF + RC + 4,
                        "R6 refresh spacing", fall_t - last_ref_t, REF);
                last_ref_t = fall_t;
                n_ref++;
            end
            if (!ras_n && host_ready) r7_viol++;
            if (host_rvalid) n_rvalid++;
            ras_p = ras_n;
            cas_p = cas_n;
        end
    end

    always @(posedge clk) begin
        if (started && cyc >= WDOG) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [13:0] addr_at(int i);
        return 14'((i * 61 + 5) % 16384);
    endfunction

    function automatic logic exp_bit(logic [13:0] a);
        return logic'((((int'(a) * 37) >> 5) & 1) ^ int'(a[0]));
    endfunction

    task automatic wait_accept();
        while (!host_ready) @(negedge clk);
        @(negedge clk);
        host_req = 1'b0;
    endtask

    task automatic finish_cycle(input logic [13:0] a);
        while (ras_n) @(negedge clk);
        while (!ras_n) @(negedge clk);
        // R2 address order
        chk(row_l == a[13:7], "R2 row at RAS", row_l, a[13:7]);
        chk(col_l == a[6:0], "R2 col at CAS", col_l, a[6:0]);
    endtask

    task automatic do_write(input logic [13:0] a, input logic d);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        wait_accept();
        finish_cycle(a);
        // R3 stored bit
        chk(mem[a] == d, "R3 write stored", mem[a], d);
    endtask

    task automatic do_read(input logic [13:0] a, input logic e);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_addr = a;
        wait_accept();
        finish_cycle(a);
        // R4 data with rvalid in first cycle after CAS release
        chk(host_rvalid == 1'b1, "R4 rvalid timing", host_rvalid, 1);
        chk(host_rdata == e, "R4 read data", host_rdata, e);
    endtask

    int n_reads = 0;

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1 during reset
        chk(ras_n && cas_n && we_n, "R1 strobes in reset", {ras_n, cas_n, we_n}, 7);
        rst = 1'b0;
        started = 1;
        @(negedge clk);
        chk(ras_n && cas_n && we_n, "R1 strobes after reset", {ras_n, cas_n, we_n}, 7);
        chk(host_ready == 1'b1, "R1 ready", host_ready, 1);
        chk(host_rvalid == 1'b0, "R1 rvalid", host_rvalid, 0);
        chk(overdue == 1'b0, "R1 overdue", overdue, 0);

        for (int i = 0; i < NACC; i++) do_write(addr_at(i), exp_bit(addr_at(i)));
        // R4 writes give no rvalid
        chk(n_rvalid == 0, "R4 no rvalid on writes", n_rvalid, 0);
        for (int i = 0; i < NACC; i++) begin
            do_read(addr_at(i), exp_bit(addr_at(i)));
            n_reads++;
        end
        for (int i = 0; i < NACC; i += 3) do_write(addr_at(i), ~exp_bit(addr_at(i)));
        for (int i = 0; i < NACC; i++) begin
            do_read(addr_at(i), (i % 3 == 0) ? ~exp_bit(addr_at(i)) : exp_bit(addr_at(i)));
            n_reads++;
        end

        // R7: request issued in the middle of a refresh
        @(negedge clk);
        while (!(!ras_n && !cas_seen && cyc - fall_t >= 1)) @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = 14'h2A55; host_wdata = 1'b1;
        chk(host_ready == 1'b0, "R7 ready low during refresh", host_ready, 0);
        wait_accept();
        finish_cycle(14'h2A55);
        chk(mem[14'h2A55] == 1'b1, "R7 held request serviced", mem[14'h2A55], 1);
        do_read(14'h2A55, 1'b1);
        n_reads++;

        repeat (20) @(negedge clk);
        chk(n_rvalid == n_reads, "R4 one rvalid per read", n_rvalid, n_reads);
        chk(r7_viol == 0, "R7 ready high while busy", r7_viol, 0);
        chk(r8_viol == 0, "R8 RAS spacing", r8_viol, 0);
        chk(n_ref > 128, "R5 counter wrapped", n_ref, 129);
        chk(n_ref >= cyc / REF - 1, "R6 refresh count", n_ref, cyc / REF);
        // R9
        chk(overdue == 1'b0, "R9 overdue stays low", overdue, 0);
        chk(u1_od == 1'b1, "R9 overdue set on short interval", u1_od, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule